// File: doc/BRIEF.md
# Cut Ranking and Node Labeling Unit

This block picks the best mapping cut for one node of a logic network during depth-oriented technology mapping. Candidate cuts for the node arrive as a stream, one cut per beat. Each beat carries up to five depth labels, one for each node of the cut, plus a mask that marks which label slots are in use and a flag that says whether the cut can really be implemented in one logic cell. The block computes three keys for each cut: the largest label, the number of nodes and the sum of the labels. It keeps the best implementable cut seen so far.

When the beat marked last has been accepted, the block reports three things: the arrival position of the winning cut, the depth label given to the node and a flag that is set when no cut qualified. The node's label is the largest label among its fan-in nodes. One is added to it when no cut survived. The fan-in maximum is taken from a side input on the first beat of each node. After the result is reported, the block is empty again and ready for the next node, with no gap cycle needed.

Top module: `cutrank_top`

## Requirements
- R1: A cut's keys are computed only over the slots whose mask bit is 1. Slot i occupies bits [8*i+7:8*i] of `in_labels` and is enabled by `in_mask[i]`. Labels in disabled slots have no effect on the keys.
- R2: Of two qualifying cuts, the one with the smaller maximum label wins.
- R3: If two cuts have equal maximum labels, the cut with fewer enabled slots wins.
- R4: If two cuts match in both maximum label and size, the cut with the smaller label sum wins.
- R5: If all three keys are equal, the cut that arrived first is kept.
- R6: A cut with `in_feasible` = 0, or with an all-zero mask, never takes part in selection.
- R7: If at least one cut qualifies, `node_label` equals the fan-in maximum and `none_feasible` = 0. Otherwise `node_label` is the fan-in maximum plus one, held at 255 when the fan-in maximum is already 255, `none_feasible` = 1 and `sel_index` = 0.
- R8: `fanin_max_label` is sampled only on the first beat of a node. Its value on later beats is ignored.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts a beat with `in_last` = 1, and is low otherwise. `sel_index` is the 0-based arrival position of the winning cut within its node.
- R10: After a node's last beat, all selection state clears. The next node's result depends only on its own beats, even when its first beat directly follows the previous last beat.
- R11: After reset, `done`, `sel_index`, `node_label` and `none_feasible` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cut is present on this beat |
| in_last | input | 1 | This beat carries the node's final cut |
| in_labels | input | 40 | Five 8-bit depth labels, slot i at bits 8*i+7..8*i |
| in_mask | input | 5 | Slot enables |
| in_feasible | input | 1 | The cut fits one logic cell |
| fanin_max_label | input | 8 | Largest fan-in label, read on the first beat |
| done | output | 1 | One-cycle result strobe |
| sel_index | output | 8 | Arrival position of the chosen cut |
| node_label | output | 8 | Depth label assigned to the node |
| none_feasible | output | 1 | No cut qualified |

## Verification
Several properties are checked on every cycle. The done strobe follows a last beat and no other beat. The state is empty whenever a result is shown. A rejected cut leaves the stored best untouched. The stored best is never worse than a cut that was just offered. The empty-result index is zero. Whether the winner is actually correct under the full three-key order, including tie handling, masked-off slot values, the saturating label step and fan-in values that change on later beats, can only be shown by the bench. It does this by comparing each node's outputs with an independently computed expectation over directed and random cut sets.

// File: rtl/cutrank_pkg.sv
package cutrank_pkg;
  localparam int NSLOT  = 5;
  localparam int LBL_W  = 8;
  localparam int SIZE_W = $clog2(NSLOT + 1);
  localparam int SUM_W  = LBL_W + $clog2(NSLOT);

  typedef logic [LBL_W-1:0] label_t;
  typedef label_t slot_arr_t [NSLOT];

  typedef struct packed {
    label_t              max_lbl;
    logic [SIZE_W-1:0]   size;
    logic [SUM_W-1:0]    sum;
  } cut_key_t;

  // Reduce gated slot labels into the three ranking keys.
  function automatic cut_key_t key_from_slots(input slot_arr_t s, input logic [NSLOT-1:0] m);
    cut_key_t k;
    k = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (m[i]) begin
        if (s[i] > k.max_lbl) k.max_lbl = s[i];
        k.size = k.size + SIZE_W'(1);
        k.sum  = k.sum + SUM_W'(s[i]);
      end
    end
    return k;
  endfunction

  // Strict lexicographic order: max label, then size, then sum.
  function automatic logic key_better(input cut_key_t a, input cut_key_t b);
    if (a.max_lbl != b.max_lbl) return a.max_lbl < b.max_lbl;
    if (a.size != b.size)       return a.size < b.size;
    return a.sum < b.sum;
  endfunction

  function automatic label_t label_step(input label_t l);
    if (l == '1) return l;
    return l + label_t'(1);
  endfunction
endpackage

// File: rtl/cutrank_key.sv
module cutrank_key
  import cutrank_pkg::*;
(
  input  logic [NSLOT*LBL_W-1:0] lbls,
  input  logic [NSLOT-1:0]       mask,
  output cut_key_t               key
);
  slot_arr_t gated;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign gated[g] = mask[g] ? lbls[g*LBL_W +: LBL_W] : '0;
  end

  always_comb key = key_from_slots(gated, mask);
endmodule

// File: rtl/cutrank_keeper.sv
module cutrank_keeper
  import cutrank_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             eligible,
  input  logic             last,
  input  cut_key_t         cand_key,
  input  logic [IDX_W-1:0] cand_idx,
  output logic             take,
  output logic             have_best,
  output logic [IDX_W-1:0] best_idx
);
  cut_key_t best_key;

  assign take = beat && eligible && (!have_best || key_better(cand_key, best_key));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_best <= 1'b0;
      best_idx  <= '0;
      best_key  <= '0;
    end else if (beat) begin
      if (last) begin
        have_best <= 1'b0;
        best_idx  <= '0;
        best_key  <= '0;
      end else if (take) begin
        have_best <= 1'b1;
        best_idx  <= cand_idx;
        best_key  <= cand_key;
      end
    end
  end

  // R6: a rejected cut leaves the stored best untouched
  p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !eligible && !last) |=> ($stable(have_best) && $stable(best_idx)));

  // R2: after any mid-node beat the stored best is not worse than the offered cut
  p_best_not_worse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eligible && !last) |=> (have_best && !key_better($past(cand_key), best_key)));
endmodule

// File: rtl/cutrank_top.sv
module cutrank_top
  import cutrank_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [NSLOT*LBL_W-1:0] in_labels,
  input  logic [NSLOT-1:0]       in_mask,
  input  logic                   in_feasible,
  input  logic [LBL_W-1:0]       fanin_max_label,
  output logic                   done,
  output logic [IDX_W-1:0]       sel_index,
  output logic [LBL_W-1:0]       node_label,
  output logic                   none_feasible
);
  cut_key_t         cand_key;
  logic             eligible;
  logic             take;
  logic             have_best;
  logic [IDX_W-1:0] best_idx;
  logic [IDX_W-1:0] beat_cnt;
  logic             mid_node;
  label_t           fanin_q;
  label_t           fanin_eff;
  logic             any_ok;
  logic             last_beat;

  cutrank_key i_key (
    .lbls (in_labels),
    .mask (in_mask),
    .key  (cand_key)
  );

  assign eligible  = in_feasible && (|in_mask);
  assign last_beat = in_valid && in_last;

  cutrank_keeper #(.IDX_W(IDX_W)) i_keeper (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (in_valid),
    .eligible  (eligible),
    .last      (in_last),
    .cand_key  (cand_key),
    .cand_idx  (beat_cnt),
    .take      (take),
    .have_best (have_best),
    .best_idx  (best_idx)
  );

  assign fanin_eff = mid_node ? fanin_q : fanin_max_label;
  assign any_ok    = take || have_best;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done          <= 1'b0;
      sel_index     <= '0;
      node_label    <= '0;
      none_feasible <= 1'b0;
      beat_cnt      <= '0;
      mid_node      <= 1'b0;
      fanin_q       <= '0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        if (!mid_node) fanin_q <= fanin_max_label;
        if (in_last) begin
          done          <= 1'b1;
          sel_index     <= take ? beat_cnt : (have_best ? best_idx : '0);
          none_feasible <= !any_ok;
          node_label    <= any_ok ? fanin_eff : label_step(fanin_eff);
          beat_cnt      <= '0;
          mid_node      <= 1'b0;
        end else begin
          beat_cnt <= beat_cnt + IDX_W'(1);
          mid_node <= 1'b1;
        end
      end
    end
  end

  // R9: a last beat produces the strobe on the next cycle
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done);

  // R9: no strobe without a last beat
  p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !last_beat |=> !done);

  // R10: state is empty while a result is shown
  p_clear_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!have_best && !mid_node && beat_cnt == '0));

  // R7: an empty result reports index zero
  p_empty_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && none_feasible) |-> (sel_index == '0));

  // R8: the captured fan-in maximum holds through the rest of the node
  p_fanin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mid_node) |=> $stable(fanin_q));
endmodule

// File: tb/test_cutrank_top.sv
`timescale 1ns/1ps
module test_cutrank_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, in_feasible;
  logic [39:0] in_labels;
  logic [4:0]  in_mask;
  logic [7:0]  fanin_max_label;
  logic        done, none_feasible;
  logic [7:0]  sel_index, node_label;

  always #2 clk = ~clk;

  cutrank_top i_cutrank_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_labels(in_labels), .in_mask(in_mask), .in_feasible(in_feasible),
    .fanin_max_label(fanin_max_label), .done(done), .sel_index(sel_index),
    .node_label(node_label), .none_feasible(none_feasible)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] c_lbl [16][5];
  logic [4:0] c_mask [16];
  logic       c_feas [16];
  int         c_n;
  logic [7:0] c_fanin;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rank value: larger label dominates, then size, then sum; smaller is better.
  function automatic int rank_of(input int c);
    int mx = 0, sz = 0, sm = 0;
    for (int s = 0; s < 5; s++)
      if (c_mask[c][s]) begin
        sz++;
        sm += c_lbl[c][s];
        if (c_lbl[c][s] > mx) mx = c_lbl[c][s];
      end
    return mx * 65536 + sz * 4096 + sm;
  endfunction

  task automatic run_node(input string req, input bit gap);
    int best = -1, bestr = 0, exp_lbl;
    for (int c = 0; c < c_n; c++)
      if (c_feas[c] && c_mask[c] != 0) begin
        int r = rank_of(c);
        if (best < 0 || r < bestr) begin best = c; bestr = r; end
      end
    if (best >= 0) exp_lbl = c_fanin;
    else exp_lbl = (c_fanin == 8'hFF) ? 255 : c_fanin + 1;
    for (int c = 0; c < c_n; c++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_last     = (c == c_n - 1);
      for (int s = 0; s < 5; s++) in_labels[s*8 +: 8] = c_lbl[c][s];
      in_mask     = c_mask[c];
      in_feasible = c_feas[c];
      fanin_max_label = (c == 0) ? c_fanin : 8'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    in_labels = 40'($urandom);
    fanin_max_label = 8'($urandom);
    check(done == 1'b1, "R9 done", done, 1);
    check(sel_index == 8'((best < 0) ? 0 : best), req, sel_index, (best < 0) ? 0 : best);
    check(none_feasible == (best < 0), "R7 none_feasible", none_feasible, best < 0);
    check(node_label == 8'(exp_lbl), "R7 R8 node_label", node_label, exp_lbl);
    if (gap) begin
      @(negedge clk);
      check(done == 1'b0, "R9 pulse width", done, 0);
    end
  endtask

  task automatic set_cut(input int c, input int l0, input int l1, input int l2,
                         input int l3, input int l4, input logic [4:0] m, input logic f);
    c_lbl[c][0] = 8'(l0); c_lbl[c][1] = 8'(l1); c_lbl[c][2] = 8'(l2);
    c_lbl[c][3] = 8'(l3); c_lbl[c][4] = 8'(l4);
    c_mask[c] = m; c_feas[c] = f;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_labels = '0;
    in_mask = '0; in_feasible = 1'b0; fanin_max_label = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(done == 0, "R11 done", done, 0);
    check(sel_index == 0, "R11 sel_index", sel_index, 0);
    check(node_label == 0, "R11 node_label", node_label, 0);
    check(none_feasible == 0, "R11 none_feasible", none_feasible, 0);

    // R2: five zeros beat smaller cuts with higher max
    c_n = 4; c_fanin = 8'd1;
    set_cut(0, 1,0,0,1,0, 5'b01111, 1);
    set_cut(1, 1,1,1,0,0, 5'b00111, 1);
    set_cut(2, 0,0,0,0,0, 5'b11111, 1);
    set_cut(3, 1,1,0,0,0, 5'b01111, 1);
    run_node("R2 max label wins", 1);
    // R3 R4: first cut infeasible, then size then sum decide
    set_cut(2, 0,0,0,0,0, 5'b11111, 0);
    set_cut(0, 0,0,0,1,0, 5'b01111, 1);
    set_cut(3, 1,1,0,0,0, 5'b01111, 1);
    set_cut(1, 1,1,1,0,0, 5'b00111, 1);
    run_node("R3 size decides", 1);
    c_n = 2;
    set_cut(0, 1,1,0,0,0, 5'b01111, 1);
    set_cut(1, 0,0,0,1,0, 5'b01111, 1);
    run_node("R4 sum decides", 1);
    // R5: identical keys keep the earlier cut
    c_n = 3;
    set_cut(0, 2,0,0,0,0, 5'b00011, 0);
    set_cut(1, 0,2,0,0,0, 5'b00011, 1);
    set_cut(2, 2,0,0,0,0, 5'b00011, 1);
    run_node("R5 tie keeps earlier", 1);
    // R6: infeasible and empty-mask cuts with better keys are ignored
    set_cut(0, 0,0,0,0,0, 5'b00000, 1);
    set_cut(1, 3,3,0,0,0, 5'b00011, 1);
    set_cut(2, 0,0,0,0,0, 5'b00001, 0);
    run_node("R6 rejected cuts", 1);
    // R7: none qualify, with saturation at 255
    c_fanin = 8'd7;
    set_cut(0, 0,0,0,0,0, 5'b00001, 0);
    set_cut(1, 0,0,0,0,0, 5'b00000, 1);
    set_cut(2, 1,0,0,0,0, 5'b00001, 0);
    run_node("R7 none feasible", 1);
    c_fanin = 8'hFF; c_n = 1;
    run_node("R7 saturate", 1);
    // R1: large labels in disabled slots must not matter
    c_n = 2; c_fanin = 8'd3;
    set_cut(0, 2,2,0,0,0, 5'b00011, 1);
    set_cut(1, 1,255,1,255,0, 5'b00101, 1);
    run_node("R1 masked slots", 1);
    // R10: back-to-back nodes, second has only worse cuts
    c_n = 1;
    set_cut(0, 0,0,0,0,0, 5'b00001, 1);
    run_node("R10 first node", 0);
    set_cut(0, 9,9,9,9,9, 5'b11111, 1);
    run_node("R10 cleared state", 1);

    // random nodes, small label range to force ties
    for (int n = 0; n < 400; n++) begin
      c_n = 1 + int'($urandom % 10);
      c_fanin = 8'($urandom % 6);
      for (int c = 0; c < c_n; c++) begin
        for (int s = 0; s < 5; s++) c_lbl[c][s] = 8'($urandom % 4);
        c_mask[c] = 5'($urandom);
        c_feas[c] = ($urandom % 4) != 0;
      end
      run_node("R1 R2 R3 R4 R5 R6 random", ($urandom % 2) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule